// File: doc/BRIEF.md
# Masked-Write Control Register Bank

This block is a bank of 32-bit memory-mapped control words on a simple bus that completes each access in one clock. Every word holds 16 data bits. The upper half of every write word does not carry data. It is a per-bit enable for the lower half. Software can therefore flip one control bit in a single write, with no read-modify-write sequence.

Words are arranged in groups of 32 on a 4-byte stride. Each implemented word has its own reset value. A word may also mix three kinds of bits:
- plain read/write bits;
- read-only status bits that mirror hardware inputs;
- a latched event bit that hardware sets and software clears by writing a one.

All implemented words are exported in parallel to the surrounding logic. One bit of one word is also brought out on its own as a half-rate clock select.

Top module: `maskreg_bank`

## Requirements
- R1: After reset the words read as follows: byte offset 0x000 reads 0x0B10, offset 0x284 reads 0xA14B, offset 0x300 reads 0xFFFF, and offsets 0x00C, 0x29C, 0x2E4, 0x2F0 and 0x380 read 0x0000 (with status bits reflecting `statusIn`, see R6).
- R2: On a write, data bit n (0..15) of the addressed word takes `wrData[n]` only when `wrData[n+16]` is 1. All other bits keep their value. A word that is not written does not change.
- R3: A word at group g, entry e sits at byte offset g*0x80 + e*4. Address bits 1:0 are ignored. The implemented words are at (group, entry) (0,0), (0,3), (5,1), (5,7), (5,25), (5,28), (6,0) and (7,0).
- R4: Read data is registered. `rdData` takes the addressed word's value as it stood before the clock edge at which `rdEn` is high, and holds that value while `rdEn` is low. Bits 31:16 always read zero. A read and a write to the same word in one cycle return the old value.
- R5: Unimplemented offsets, including the reserved entries 24..31 of group 7 (offsets 0x3E0..0x3FC), read as zero, and writes to them change no word.
- R6: Bits 9:6 of offset 0x2E4 show `statusIn[3:0]` and bits 9:6 of offset 0x2F0 show `statusIn[7:4]`. Writes cannot change these bits.
- R7: Bit 14 of offset 0x29C is a latched event. It becomes 1 at the edge after `evtSet` is high and stays 1. A write with `wrData[30]` and `wrData[14]` both 1 clears it. If `evtSet` is high in the same cycle as a clear, the set wins. Ordinary writes cannot set this bit.
- R8: `clkHalfSel` equals bit 10 of offset 0x00C (0 selects the full-rate clock, 1 the half-rate clock).
- R9: `regOut` carries all implemented words at all times, 16 bits each. Lane k holds the k-th word in the order listed in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one access per cycle |
| rdEn | input | 1 | Read strobe |
| addr | input | ADDR_W (12) | Byte address |
| wrData | input | 32 | Write mask in 31:16, write data in 15:0 |
| rdData | output | 32 | Registered read data, bits 31:16 zero |
| evtSet | input | 1 | Hardware set of the latched event bit |
| statusIn | input | 8 | Hardware status, two lanes of 4 bits |
| regOut | output | 128 | All implemented words, lane k at bits 16k+15:16k |
| clkHalfSel | output | 1 | Half-rate clock select |

## Verification
The bound checker watches, on every cycle, the following:
- that read data holds between reads;
- that reserved group-7 reads return zero;
- that the plain word and the clock select move only on writes;
- that the event bit obeys its set, hold and clear rules with set-over-clear priority;
- that the first status lane always reaches its word.

The directed scenarios and the clocked reference model cover what a property cannot see alone: each word's reset value, the exact merging of masked data, address aliasing through the ignored low bits, the old-value return on a same-cycle read and write, and the fact that reserved writes leave every other word untouched.

// File: rtl/maskreg_pkg.sv
package maskreg_pkg;

  localparam int DATA_W            = 16;
  localparam int BUS_W             = 2 * DATA_W;
  localparam int NUM_REGS          = 8;
  localparam int ENTRIES_PER_GROUP = 32;
  localparam int ENTRY_W           = $clog2(ENTRIES_PER_GROUP);
  localparam int STAT_W            = 4;
  localparam int STAT_LANES        = 2;
  localparam int STAT_LSB          = 6;
  localparam int RSV_GROUP         = 7;
  localparam int RSV_FIRST         = 24;
  localparam int EVT_REG           = 3;
  localparam int EVT_BIT           = 14;
  localparam int CLKDIV_REG        = 1;
  localparam int CLKDIV_BIT        = 10;

  function automatic int unsigned wordOf(input int unsigned grp, input int unsigned ent);
    return grp * ENTRIES_PER_GROUP + ent;
  endfunction

  // Word index (byte offset / 4) of register slot i.
  function automatic int unsigned regWord(input int i);
    case (i)
      0:       return wordOf(0, 0);
      1:       return wordOf(0, 3);
      2:       return wordOf(5, 1);
      3:       return wordOf(5, 7);
      4:       return wordOf(5, 25);
      5:       return wordOf(5, 28);
      6:       return wordOf(6, 0);
      default: return wordOf(7, 0);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regReset(input int i);
    case (i)
      0:       return 16'h0B10;
      2:       return 16'hA14B;
      6:       return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] regRoMask(input int i);
    if (i == 4 || i == 5) return DATA_W'(((1 << STAT_W) - 1) << STAT_LSB);
    return '0;
  endfunction

  function automatic logic [DATA_W-1:0] regW1cMask(input int i);
    if (i == EVT_REG) return DATA_W'(1 << EVT_BIT);
    return '0;
  endfunction

  function automatic int regStatLane(input int i);
    return (i == 5) ? 1 : 0;
  endfunction

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;
    logic [NUM_REGS-1:0] rdSel;
    logic                rdStrobe;
  } strobe_t;

endpackage

// File: rtl/maskreg_ctrl.sv
module maskreg_ctrl
  import maskreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  output strobe_t           strb
);

  localparam int WIDX_W  = ADDR_W - 2;
  localparam int GROUP_W = WIDX_W - ENTRY_W;

  logic [WIDX_W-1:0]   wordIdx;
  logic                unusedByteLane;
  logic                isReserved;
  logic [NUM_REGS-1:0] hit;

  assign wordIdx        = addr[ADDR_W-1:2];
  assign unusedByteLane = ^addr[1:0];

  assign isReserved = (wordIdx[WIDX_W-1:ENTRY_W] == GROUP_W'(RSV_GROUP)) &&
                      (wordIdx[ENTRY_W-1:0] >= ENTRY_W'(RSV_FIRST));

  for (genvar i = 0; i < NUM_REGS; i++) begin : gHit
    localparam logic [WIDX_W-1:0] WORD = WIDX_W'(regWord(i));
    assign hit[i] = (wordIdx == WORD) && !isReserved;
  end

  always_comb begin
    strb.wrSel    = hit & {NUM_REGS{wrEn}};
    strb.rdSel    = hit & {NUM_REGS{rdEn}};
    strb.rdStrobe = rdEn;
  end

endmodule

// File: rtl/maskreg_dpath.sv
module maskreg_dpath
  import maskreg_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  strobe_t                      strb,
  input  logic [BUS_W-1:0]             wrData,
  input  logic                         evtSet,
  input  logic [STAT_W*STAT_LANES-1:0] statusIn,
  output logic [NUM_REGS*DATA_W-1:0]   regView,
  output logic [BUS_W-1:0]             rdData
);

  logic [DATA_W-1:0] viewArr [NUM_REGS];
  logic [DATA_W-1:0] wrMask;
  logic [DATA_W-1:0] wrBits;
  logic [DATA_W-1:0] rdMux;
  logic [DATA_W-1:0] rdQ;

  assign wrMask = wrData[BUS_W-1:DATA_W];
  assign wrBits = wrData[DATA_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : gReg
    localparam logic [DATA_W-1:0] RST   = regReset(i);
    localparam logic [DATA_W-1:0] RO    = regRoMask(i);
    localparam logic [DATA_W-1:0] W1C   = regW1cMask(i);
    localparam logic [DATA_W-1:0] WMASK = ~(RO | W1C);

    logic [DATA_W-1:0] store;
    logic [DATA_W-1:0] evtQ;
    logic [DATA_W-1:0] statBits;
    logic [DATA_W-1:0] laneMask;

    assign laneMask = wrMask & WMASK;

    always_ff @(posedge clk) begin
      if (!rstN)               store <= RST & WMASK;
      else if (strb.wrSel[i])  store <= (store & ~laneMask) | (wrBits & laneMask);
    end

    if (W1C != '0) begin : gEvt
      logic [DATA_W-1:0] clrBits;
      assign clrBits = strb.wrSel[i] ? (wrMask & wrBits & W1C) : '0;
      always_ff @(posedge clk) begin
        if (!rstN) evtQ <= RST & W1C;
        else       evtQ <= (evtQ & ~clrBits) | (W1C & {DATA_W{evtSet}});
      end
    end else begin : gNoEvt
      assign evtQ = '0;
    end

    if (RO != '0) begin : gStat
      localparam int LANE = regStatLane(i);
      assign statBits = DATA_W'(statusIn[LANE*STAT_W +: STAT_W]) << STAT_LSB;
    end else begin : gNoStat
      assign statBits = '0;
    end

    assign viewArr[i] = (store & WMASK) | (evtQ & W1C) | (statBits & RO);
    assign regView[i*DATA_W +: DATA_W] = viewArr[i];
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (strb.rdSel[k]) rdMux = rdMux | viewArr[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              rdQ <= '0;
    else if (strb.rdStrobe) rdQ <= rdMux;
  end

  assign rdData = {{(BUS_W-DATA_W){1'b0}}, rdQ};

endmodule

// File: rtl/maskreg_bank.sv
module maskreg_bank
  import maskreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic                         rdEn,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [BUS_W-1:0]             wrData,
  output logic [BUS_W-1:0]             rdData,
  input  logic                         evtSet,
  input  logic [STAT_W*STAT_LANES-1:0] statusIn,
  output logic [NUM_REGS*DATA_W-1:0]   regOut,
  output logic                         clkHalfSel
);

  strobe_t strb;

  maskreg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wrEn (wrEn),
    .rdEn (rdEn),
    .addr (addr),
    .strb (strb)
  );

  maskreg_dpath uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .evtSet   (evtSet),
    .statusIn (statusIn),
    .regView  (regOut),
    .rdData   (rdData)
  );

  assign clkHalfSel = regOut[CLKDIV_REG*DATA_W + CLKDIV_BIT];

endmodule

// File: rtl/maskreg_bank_chk.sv
module maskreg_bank_chk
  import maskreg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         wrEn,
  input logic                         rdEn,
  input logic [ADDR_W-1:0]            addr,
  input logic [BUS_W-1:0]             wrData,
  input logic [BUS_W-1:0]             rdData,
  input logic                         evtSet,
  input logic [STAT_W*STAT_LANES-1:0] statusIn,
  input logic [NUM_REGS*DATA_W-1:0]   regOut,
  input logic                         clkHalfSel
);

  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] EVT_WORD = WIDX_W'(regWord(EVT_REG));
  localparam logic [WIDX_W-1:0] RSV_LO   = WIDX_W'(wordOf(RSV_GROUP, RSV_FIRST));
  localparam logic [WIDX_W-1:0] RSV_HI   = WIDX_W'(wordOf(RSV_GROUP, ENTRIES_PER_GROUP - 1));

  logic evtBit;
  logic clrReq;
  logic rsvRead;

  assign evtBit  = regOut[EVT_REG*DATA_W + EVT_BIT];
  assign clrReq  = wrEn && (addr[ADDR_W-1:2] == EVT_WORD) &&
                   wrData[DATA_W + EVT_BIT] && wrData[EVT_BIT];
  assign rsvRead = rdEn && (addr[ADDR_W-1:2] >= RSV_LO) && (addr[ADDR_W-1:2] <= RSV_HI);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData)); // R4

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rsvRead |=> (rdData == '0)); // R5

  AST_PLAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(regOut[DATA_W-1:0])); // R2

  AST_CLKDIV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(clkHalfSel)); // R8

  AST_EVT_SET: assert property (@(posedge clk) disable iff (!rstN)
    evtSet |=> evtBit); // R7

  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (evtBit && !clrReq) |=> evtBit); // R7

  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !evtSet) |=> !evtBit); // R7

  AST_EVT_NO_SW_SET: assert property (@(posedge clk) disable iff (!rstN)
    (!evtBit && !evtSet) |=> !evtBit); // R7

  AST_STATUS_LANE0: assert property (@(posedge clk) disable iff (!rstN)
    regOut[4*DATA_W + STAT_LSB +: STAT_W] == statusIn[STAT_W-1:0]); // R6

endmodule

bind maskreg_bank maskreg_bank_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .rdEn       (rdEn),
  .addr       (addr),
  .wrData     (wrData),
  .rdData     (rdData),
  .evtSet     (evtSet),
  .statusIn   (statusIn),
  .regOut     (regOut),
  .clkHalfSel (clkHalfSel)
);

// File: tb/tb_maskreg_bank.sv
module tb_maskreg_bank;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        evtSet = 1'b0;
  logic [7:0]  statusIn = '0;
  logic [127:0] regOut;
  logic        clkHalfSel;

  maskreg_bank #(.ADDR_W(AW)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .evtSet(evtSet), .statusIn(statusIn),
    .regOut(regOut), .clkHalfSel(clkHalfSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  bit done    = 0;
  string curReq = "R1";

  // Reference model state
  int          offs [8] = '{'h000, 'h00C, 'h284, 'h29C, 'h2E4, 'h2F0, 'h300, 'h380};
  logic [15:0] rstv [8] = '{16'h0B10, 16'h0, 16'hA14B, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h0};
  logic [15:0] mVal [8];
  logic        mEvt;
  logic [15:0] rdExp;

  function automatic int laneOf(input logic [AW-1:0] a);
    for (int k = 0; k < 8; k++) if ((offs[k] >> 2) == int'(a >> 2)) return k;
    return -1;
  endfunction

  function automatic logic [15:0] mView(input int k);
    logic [15:0] v;
    v = mVal[k];
    if (k == 3) v[14] = mEvt;
    if (k == 4) v[9:6] = statusIn[3:0];
    if (k == 5) v[9:6] = statusIn[7:4];
    return v;
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 8; k++) mVal[k] = rstv[k];
    mEvt  = 1'b0;
    rdExp = 16'h0;
  endtask

  task automatic modelEdge();
    int k;
    logic [15:0] m, d;
    bit clr;
    clr = 0;
    k = laneOf(addr);
    if (rdEn) rdExp = (k >= 0) ? mView(k) : 16'h0;
    if (wrEn && k >= 0) begin
      m = wrData[31:16];
      d = wrData[15:0];
      if (k == 4 || k == 5) m = m & ~16'h03C0;
      if (k == 3) begin
        clr = m[14] && d[14];
        m = m & ~16'h4000;
      end
      mVal[k] = (mVal[k] & ~m) | (d & m);
    end
    if (evtSet) mEvt = 1'b1;
    else if (clr) mEvt = 1'b0;
  endtask

  task automatic compareAll();
    vectors++;
    if (rdData !== {16'h0, rdExp}) begin
      errors++;
      $display("FAIL %s rdData act=%h exp=%h", curReq, rdData, {16'h0, rdExp});
    end
    for (int k = 0; k < 8; k++) begin
      if (regOut[k*16 +: 16] !== mView(k)) begin
        errors++;
        $display("FAIL R9 (%s) regOut lane %0d act=%h exp=%h", curReq, k, regOut[k*16 +: 16], mView(k));
      end
    end
    if (clkHalfSel !== mVal[1][10]) begin
      errors++;
      $display("FAIL R8 clkHalfSel act=%b exp=%b", clkHalfSel, mVal[1][10]);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    modelEdge();
    compareAll();
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    step();
    wrEn = 1'b0;
  endtask

  task automatic rdExpect(input logic [AW-1:0] a, input logic [15:0] exp, input string req);
    rdEn = 1'b1; addr = a;
    step();
    rdEn = 1'b0;
    vectors++;
    if (rdData !== {16'h0, exp}) begin
      errors++;
      $display("FAIL %s read %h act=%h exp=%h", req, a, rdData, {16'h0, exp});
    end
  endtask

  task automatic pinCheck(input logic act, input logic exp, input string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pin act=%b exp=%b", req, act, exp);
    end
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset values
    curReq = "R1";
    rdExpect(12'h000, 16'h0B10, "R1");
    rdExpect(12'h284, 16'hA14B, "R1");
    rdExpect(12'h300, 16'hFFFF, "R1");
    rdExpect(12'h00C, 16'h0000, "R1");
    rdExpect(12'h29C, 16'h0000, "R1");
    rdExpect(12'h380, 16'h0000, "R1");
    pinCheck(clkHalfSel, 1'b0, "R1");

    // R2 masked writes
    curReq = "R2";
    wr(12'h000, 32'h0000_FFFF);
    rdExpect(12'h000, 16'h0B10, "R2");
    wr(12'h000, 32'h00F0_00A0);
    rdExpect(12'h000, 16'h0BA0, "R2");
    wr(12'h000, 32'h8001_FFFF);
    rdExpect(12'h000, 16'h8BA1, "R2");

    // R3 address map, low bits ignored
    curReq = "R3";
    wr(12'h383, 32'hFFFF_1357);
    rdExpect(12'h381, 16'h1357, "R3");
    wr(12'h302, 32'h0F00_0000);
    rdExpect(12'h300, 16'hF0FF, "R3");

    // R5 reserved and unmapped
    curReq = "R5";
    wr(12'h3E0, 32'hFFFF_FFFF);
    wr(12'h3FC, 32'hFFFF_FFFF);
    wr(12'h004, 32'hFFFF_FFFF);
    rdExpect(12'h3E0, 16'h0000, "R5");
    rdExpect(12'h3FC, 16'h0000, "R5");
    rdExpect(12'h004, 16'h0000, "R5");
    rdExpect(12'h380, 16'h1357, "R5");

    // R6 read-only status
    curReq = "R6";
    statusIn = 8'hA5;
    rdExpect(12'h2E4, 16'h0140, "R6");
    rdExpect(12'h2F0, 16'h0280, "R6");
    wr(12'h2E4, 32'hFFFF_0000);
    rdExpect(12'h2E4, 16'h0140, "R6");
    wr(12'h2E4, 32'hFFFF_FC3F);
    rdExpect(12'h2E4, 16'hFD7F, "R6");
    statusIn = 8'h3C;
    rdExpect(12'h2E4, 16'hFF3F, "R6");

    // R7 latched event
    curReq = "R7";
    wr(12'h29C, 32'hFFFF_4000);
    rdExpect(12'h29C, 16'h0000, "R7");
    evtSet = 1'b1;
    step();
    evtSet = 1'b0;
    pinCheck(regOut[3*16+14], 1'b1, "R7");
    wr(12'h29C, 32'h0000_4000);
    rdExpect(12'h29C, 16'h4000, "R7");
    wr(12'h29C, 32'h4000_4000);
    rdExpect(12'h29C, 16'h0000, "R7");
    evtSet = 1'b1;
    step();
    evtSet = 1'b1;
    wr(12'h29C, 32'h4000_4000);
    evtSet = 1'b0;
    rdExpect(12'h29C, 16'h4000, "R7");

    // R8 clock divide select
    curReq = "R8";
    wr(12'h00C, 32'hFFFF_0400);
    pinCheck(clkHalfSel, 1'b1, "R8");
    wr(12'h00C, 32'h0400_0000);
    pinCheck(clkHalfSel, 1'b0, "R8");
    wr(12'h00C, 32'hFBFF_FFFF);
    pinCheck(clkHalfSel, 1'b0, "R8");

    // R4 read timing
    curReq = "R4";
    rdEn = 1'b1; addr = 12'h284;
    step();
    rdEn = 1'b0; addr = 12'h000;
    step();
    vectors++;
    if (rdData !== 32'h0000_A14B) begin
      errors++;
      $display("FAIL R4 hold act=%h exp=%h", rdData, 32'h0000_A14B);
    end
    rdEn = 1'b1; wrEn = 1'b1; addr = 12'h284; wrData = 32'hFFFF_0000;
    step();
    rdEn = 1'b0; wrEn = 1'b0;
    vectors++;
    if (rdData !== 32'h0000_A14B) begin
      errors++;
      $display("FAIL R4 same-cycle act=%h exp=%h", rdData, 32'h0000_A14B);
    end
    rdExpect(12'h284, 16'h0000, "R4");

    // R9 mixed traffic against the model
    curReq = "R9";
    for (int n = 0; n < 400; n++) begin
      int pick;
      pick = $urandom_range(0, 9);
      addr = (pick < 8) ? AW'(offs[pick] + $urandom_range(0, 3))
                        : AW'('h3E0 + 4 * $urandom_range(0, 7));
      wrEn = $urandom_range(0, 1);
      rdEn = $urandom_range(0, 1);
      wrData = $urandom;
      evtSet = ($urandom_range(0, 7) == 0);
      statusIn = 8'($urandom);
      step();
    end
    wrEn = 1'b0; rdEn = 1'b0; evtSet = 1'b0;
    step();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule